// File: doc/BRIEF.md
# Display Status and Interrupt Unit

This block keeps the control state of a vector display controller and answers the three host commands that touch it: unit reset, sense interrupt and sense status. It holds the X and Y beam deflection registers, the drawing mode, the light-pen control, three latched interrupt sources, a deferred-detect flag, the light-pen switch sample, the busy (regenerating) flag, a 2-bit address displacement and a bank of programmed-function indicators. Beam drawing, memory access, keyboard scanning and the pen hardware are outside the block and reach it only as single-cycle event pulses and configuration writes.

A command is presented for one clock on `cmd_vld` with an opcode (`cmd_op`: 0 none, 1 reset, 2 sense interrupt, 3 sense status), a 5-bit device address that is never decoded, and a 16-bit data word. The answer comes back one clock later as a one-cycle `rsp_vld` pulse with `rsp_data`. In this document status bit n means `rsp_data[n]`. The sensed word always reflects the state before the command's clock edge. Events that arrive in the same cycle take effect after that edge.

Top module: `disp_status_unit`

## Requirements
- R1: A reset command, or `rst_n` low, sets `defl_x` and `defl_y` to the grid midpoint (512 at the default width of 10 bits). It clears every interrupt source, detect status, pen switch sample and busy. A reset command takes priority over every other input in its cycle and answers with `rsp_vld` high and `rsp_data` 0.
- R2: After any reset the mode is vector, so status bits 9 and 10 read 0. Light-pen detects are disabled and their interrupts deferred, so a pen detect event changes nothing. The address displacement (status bits 15:14) reads binary 01.
- R3: A reset command copies its 16-bit data word into every 16-bit copy of `ind`. With the default of 2 copies, `ind[15:0]` and `ind[31:16]` both equal the data. A 1 sets and a 0 clears both matching indicators. `rst_n` clears all indicators.
- R4: A sense status issued while busy returns exactly 16'h0100 (only bit 8 set).
- R5: A sense status issued while not busy returns the following bits: bit 0 order interrupt, bit 1 keyboard interrupt, bit 2 detect interrupt, bit 4 detect status, bit 7 pen switch sample, bit 8 as 0, bit 9 character mode, bit 10 point mode, bits 15:14 displacement. Bits 3, 5, 6 and 11 to 13 are always 0.
- R6: A pen detect event with detects enabled does one of two things. If interrupts are deferred, it sets detect status (bit 4). If interrupts are enabled, it sets detect interrupt (bit 2), clears bit 4 and loads `ev_pen_disp` into the displacement. Bit 4 clears after a not-busy sense status that returned it as 1.
- R7: Any new interrupt event clears busy. `ev_regen_start` sets busy only while no interrupt is pending and is otherwise ignored.
- R8: A sense interrupt command with an interrupt pending and `host_lvl_act` high answers with `rsp_data` 16'h0010 (only bit 4 set). It leaves the pending sources unchanged.
- R9: A sense interrupt command with nothing pending, or with `host_lvl_act` low, produces no `rsp_vld` pulse.
- R10: A not-busy sense status with `cmd_data[8]` set first returns the word, then clears bits 0 to 2.
- R11: `cmd_dev` has no effect on any command.
- R12: `irq_req` is high exactly when at least one of status bits 0 to 2 is pending and the unit is not busy.
- R13: `rsp_vld` is a single-cycle pulse one clock after the command strobe, and it never rises without a command.
- R14: `cfg_we` loads the mode (`cfg_mode`: 0 vector, 1 point, 2 or 3 character) and the pen control. `ev_timer_start` samples `pen_switch` into status bit 7. Deflection writes through `defl_we` take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 2 | Command opcode |
| cmd_dev | input | 5 | Device address, ignored |
| cmd_data | input | 16 | Command data word |
| host_lvl_act | input | 1 | Host interrupt level active |
| cfg_we | input | 1 | Mode and pen control write |
| cfg_mode | input | 2 | Drawing mode |
| cfg_pen_det | input | 1 | Enable pen detects |
| cfg_pen_irq | input | 1 | 1 = detect interrupts enabled, 0 = deferred |
| defl_we | input | 1 | Deflection write |
| defl_x_in | input | DEFL_W | New X deflection |
| defl_y_in | input | DEFL_W | New Y deflection |
| ev_regen_start | input | 1 | Regeneration starts |
| ev_order_irq | input | 1 | Order-controlled interrupt event |
| ev_key_irq | input | 1 | Keyboard interrupt event |
| ev_pen_detect | input | 1 | Light-pen detect event |
| ev_pen_disp | input | 2 | Displacement captured with a detect interrupt |
| ev_timer_start | input | 1 | Timer start order, samples pen switch |
| pen_switch | input | 1 | Light-pen switch level |
| rsp_vld | output | 1 | Response valid pulse |
| rsp_data | output | 16 | Response word |
| irq_req | output | 1 | Interrupt request |
| busy | output | 1 | Regenerating |
| defl_x | output | DEFL_W | X deflection |
| defl_y | output | DEFL_W | Y deflection |
| ind | output | 16*IND_COPIES | Programmed-function indicators |

## Verification
The bench builds the unit with its defaults: a 10-bit deflection width and two indicator copies. With these values the midpoint is the concrete value 512 and the two mirrored indicator halves are visible as one 32-bit output. The table walk covers all the corner cases in order: the busy mask, clearing detect status by reading it, the conditional sense interrupt and the displacement capture. Directed steps then cover reset priority over a pending deflection load, indicator mirroring with two different patterns, and the interaction between busy and `irq_req`.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      OP_NONE       = 2'd0,
      OP_RESET      = 2'd1,
      OP_SENSE_INT  = 2'd2,
      OP_SENSE_STAT = 2'd3
   } dsu_op_e;

   typedef enum logic [1:0] {
      MODE_VECTOR  = 2'd0,
      MODE_POINT   = 2'd1,
      MODE_CHAR    = 2'd2,
      MODE_CHAR_LG = 2'd3
   } dsu_mode_e;

   // status word bit positions (decoded by host software)
   localparam int SB_ORDER   = 0;
   localparam int SB_KEY     = 1;
   localparam int SB_DETIRQ  = 2;
   localparam int SB_DETSTAT = 4;
   localparam int SB_PENSW   = 7;
   localparam int SB_BUSY    = 8;
   localparam int SB_CHAR    = 9;
   localparam int SB_POINT   = 10;
   localparam int SB_DISP    = 14;
   localparam int CB_CLRIRQ  = 8;

   localparam logic [WORD_W-1:0] RSVD_MASK = 16'h3868;
   localparam logic [WORD_W-1:0] BUSY_WORD = 16'h0100;
   localparam logic [WORD_W-1:0] SINT_WORD = 16'h0010;
   localparam logic [1:0]        DISP_RST  = 2'b01;

   localparam int NSRC = 3; // [0] order, [1] key, [2] detect
endpackage

// File: rtl/dsu_ctrl_regs.sv
module dsu_ctrl_regs
   import dsu_pkg::*;
#(
   parameter int DEFL_W     = 10,
   parameter int IND_COPIES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic [WORD_W-1:0]            soft_data,
   input  logic                         cfg_we,
   input  logic [1:0]                   cfg_mode,
   input  logic                         cfg_pen_det,
   input  logic                         cfg_pen_irq,
   input  logic                         defl_we,
   input  logic [DEFL_W-1:0]            defl_x_in,
   input  logic [DEFL_W-1:0]            defl_y_in,
   output dsu_mode_e                    mode_q,
   output logic                         pen_det_q,
   output logic                         pen_irq_q,
   output logic [DEFL_W-1:0]            defl_x_q,
   output logic [DEFL_W-1:0]            defl_y_q,
   output logic [IND_COPIES*WORD_W-1:0] ind_q
);
   localparam logic [DEFL_W-1:0] DEFL_MID = {1'b1, {(DEFL_W-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_VECTOR;
         pen_det_q <= 1'b0;
         pen_irq_q <= 1'b0;
      end else if (soft_rst) begin
         mode_q    <= MODE_VECTOR;
         pen_det_q <= 1'b0;
         pen_irq_q <= 1'b0;
      end else if (cfg_we) begin
         mode_q    <= dsu_mode_e'(cfg_mode);
         pen_det_q <= cfg_pen_det;
         pen_irq_q <= cfg_pen_irq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         defl_x_q <= DEFL_MID;
         defl_y_q <= DEFL_MID;
      end else if (soft_rst) begin
         defl_x_q <= DEFL_MID;
         defl_y_q <= DEFL_MID;
      end else if (defl_we) begin
         defl_x_q <= defl_x_in;
         defl_y_q <= defl_y_in;
      end
   end

   for (genvar g = 0; g < IND_COPIES; g++) begin : g_ind
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ind_q[g*WORD_W +: WORD_W] <= '0;
         else if (soft_rst) ind_q[g*WORD_W +: WORD_W] <= soft_data;
      end

      AST_IND_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
         soft_rst |=> ind_q[g*WORD_W +: WORD_W] == $past(soft_data)); // R3
   end

   AST_DEFL_MID: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (defl_x_q == DEFL_MID && defl_y_q == DEFL_MID)); // R1

   AST_MODE_RST: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode_q == MODE_VECTOR && !pen_det_q && !pen_irq_q)); // R2
endmodule

// File: rtl/dsu_irq_state.sv
module dsu_irq_state
   import dsu_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            stat_read,
   input  logic            clr_irq,
   input  logic            pen_det,
   input  logic            pen_irq,
   input  logic            ev_regen_start,
   input  logic            ev_order,
   input  logic            ev_key,
   input  logic            ev_pen_detect,
   input  logic [1:0]      ev_disp,
   input  logic            ev_timer,
   input  logic            pen_switch,
   output logic [NSRC-1:0] pend_q,
   output logic            det_stat_q,
   output logic            pensw_q,
   output logic            busy_q,
   output logic [1:0]      disp_q
);
   logic det_en, det_int, det_def, any_new, rd_ok;

   assign det_en  = ev_pen_detect & pen_det;
   assign det_int = det_en & pen_irq;
   assign det_def = det_en & ~pen_irq;
   assign any_new = ev_order | ev_key | det_int;
   assign rd_ok   = stat_read & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         det_stat_q <= 1'b0;
         pensw_q    <= 1'b0;
         busy_q     <= 1'b0;
         disp_q     <= DISP_RST;
      end else if (soft_rst) begin
         pend_q     <= '0;
         det_stat_q <= 1'b0;
         pensw_q    <= 1'b0;
         busy_q     <= 1'b0;
         disp_q     <= DISP_RST;
      end else begin
         pend_q <= ((rd_ok && clr_irq) ? '0 : pend_q) | {det_int, ev_key, ev_order};
         if (det_def)
            det_stat_q <= 1'b1;
         else if (det_int || (rd_ok && det_stat_q))
            det_stat_q <= 1'b0;
         if (any_new)
            busy_q <= 1'b0;
         else if (ev_regen_start && pend_q == '0)
            busy_q <= 1'b1;
         if (ev_timer) pensw_q <= pen_switch;
         if (det_int)  disp_q  <= ev_disp;
      end
   end

   AST_BUSY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> pend_q == '0); // R7

   AST_DETSTAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (det_int && !soft_rst) |=> !det_stat_q); // R6

   AST_DISP_RST: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> disp_q == DISP_RST); // R2
endmodule

// File: rtl/dsu_rsp.sv
module dsu_rsp
   import dsu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_reset,
   input  logic              is_sint,
   input  logic              is_sstat,
   input  logic              host_lvl,
   input  logic [NSRC-1:0]   pend,
   input  logic              det_stat,
   input  logic              pensw,
   input  logic              busy,
   input  dsu_mode_e         mode,
   input  logic [1:0]        disp,
   output logic              rsp_vld,
   output logic [WORD_W-1:0] rsp_data,
   output logic              irq_req
);
   logic [WORD_W-1:0] word;
   logic              sint_go;

   always_comb begin
      word                    = '0;
      word[SB_ORDER]          = pend[0];
      word[SB_KEY]            = pend[1];
      word[SB_DETIRQ]         = pend[2];
      word[SB_DETSTAT]        = det_stat;
      word[SB_PENSW]          = pensw;
      word[SB_CHAR]           = mode[1];
      word[SB_POINT]          = (mode == MODE_POINT);
      word[SB_DISP +: 2]      = disp;
   end

   assign sint_go = is_sint & host_lvl & (|pend);
   assign irq_req = (|pend) & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_data <= '0;
      end else if (is_reset) begin
         rsp_vld  <= 1'b1;
         rsp_data <= '0;
      end else if (sint_go) begin
         rsp_vld  <= 1'b1;
         rsp_data <= SINT_WORD;
      end else if (is_sstat) begin
         rsp_vld  <= 1'b1;
         rsp_data <= busy ? BUSY_WORD : word;
      end else begin
         rsp_vld  <= 1'b0;
         rsp_data <= '0;
      end
   end

   AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sstat && busy) |=> (rsp_vld && rsp_data == BUSY_WORD)); // R4

   AST_SINT_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sint && !(host_lvl && pend != '0)) |=> !rsp_vld); // R9

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> (rsp_data & RSVD_MASK) == '0); // R5

   AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $past(is_reset || is_sint || is_sstat)); // R13
endmodule

// File: rtl/disp_status_unit.sv
module disp_status_unit
   import dsu_pkg::*;
#(
   parameter int DEFL_W     = 10,
   parameter int IND_COPIES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_vld,
   input  logic [1:0]                   cmd_op,
   input  logic [4:0]                   cmd_dev,
   input  logic [15:0]                  cmd_data,
   input  logic                         host_lvl_act,
   input  logic                         cfg_we,
   input  logic [1:0]                   cfg_mode,
   input  logic                         cfg_pen_det,
   input  logic                         cfg_pen_irq,
   input  logic                         defl_we,
   input  logic [DEFL_W-1:0]            defl_x_in,
   input  logic [DEFL_W-1:0]            defl_y_in,
   input  logic                         ev_regen_start,
   input  logic                         ev_order_irq,
   input  logic                         ev_key_irq,
   input  logic                         ev_pen_detect,
   input  logic [1:0]                   ev_pen_disp,
   input  logic                         ev_timer_start,
   input  logic                         pen_switch,
   output logic                         rsp_vld,
   output logic [15:0]                  rsp_data,
   output logic                         irq_req,
   output logic                         busy,
   output logic [DEFL_W-1:0]            defl_x,
   output logic [DEFL_W-1:0]            defl_y,
   output logic [IND_COPIES*16-1:0]     ind
);
   if (DEFL_W < 2 || DEFL_W > 16) begin : g_bad_defl
      $error("DEFL_W must lie in 2..16");
   end
   if (IND_COPIES < 1 || IND_COPIES > 8) begin : g_bad_ind
      $error("IND_COPIES must lie in 1..8");
   end

   dsu_op_e        op;
   logic           is_reset, is_sint, is_sstat;
   dsu_mode_e      mode_q;
   logic           pen_det_q, pen_irq_q;
   logic [NSRC-1:0] pend_q;
   logic           det_stat_q, pensw_q;
   logic [1:0]     disp_q;
   logic           unused_dev;

   assign unused_dev = ^cmd_dev; // device address is never decoded (R11)
   assign op        = dsu_op_e'(cmd_op);
   assign is_reset  = cmd_vld && op == OP_RESET;
   assign is_sint   = cmd_vld && op == OP_SENSE_INT;
   assign is_sstat  = cmd_vld && op == OP_SENSE_STAT;

   dsu_ctrl_regs #(.DEFL_W(DEFL_W), .IND_COPIES(IND_COPIES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (is_reset),
      .soft_data  (cmd_data),
      .cfg_we     (cfg_we),
      .cfg_mode   (cfg_mode),
      .cfg_pen_det(cfg_pen_det),
      .cfg_pen_irq(cfg_pen_irq),
      .defl_we    (defl_we),
      .defl_x_in  (defl_x_in),
      .defl_y_in  (defl_y_in),
      .mode_q     (mode_q),
      .pen_det_q  (pen_det_q),
      .pen_irq_q  (pen_irq_q),
      .defl_x_q   (defl_x),
      .defl_y_q   (defl_y),
      .ind_q      (ind)
   );

   dsu_irq_state u_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .soft_rst      (is_reset),
      .stat_read     (is_sstat),
      .clr_irq       (cmd_data[CB_CLRIRQ]),
      .pen_det       (pen_det_q),
      .pen_irq       (pen_irq_q),
      .ev_regen_start(ev_regen_start),
      .ev_order      (ev_order_irq),
      .ev_key        (ev_key_irq),
      .ev_pen_detect (ev_pen_detect),
      .ev_disp       (ev_pen_disp),
      .ev_timer      (ev_timer_start),
      .pen_switch    (pen_switch),
      .pend_q        (pend_q),
      .det_stat_q    (det_stat_q),
      .pensw_q       (pensw_q),
      .busy_q        (busy),
      .disp_q        (disp_q)
   );

   dsu_rsp u_rsp (
      .clk     (clk),
      .rst_n   (rst_n),
      .is_reset(is_reset),
      .is_sint (is_sint),
      .is_sstat(is_sstat),
      .host_lvl(host_lvl_act),
      .pend    (pend_q),
      .det_stat(det_stat_q),
      .pensw   (pensw_q),
      .busy    (busy),
      .mode    (mode_q),
      .disp    (disp_q),
      .rsp_vld (rsp_vld),
      .rsp_data(rsp_data),
      .irq_req (irq_req)
   );

   AST_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !irq_req); // R12
endmodule

// File: tb/sim_disp_status_unit.sv
module sim_disp_status_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_vld = 0;
   logic [1:0]  cmd_op = 0;
   logic [4:0]  cmd_dev = 0;
   logic [15:0] cmd_data = 0;
   logic        host_lvl_act = 0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_mode = 0;
   logic        cfg_pen_det = 0, cfg_pen_irq = 0;
   logic        defl_we = 0;
   logic [9:0]  defl_x_in = 0, defl_y_in = 0;
   logic        ev_regen_start = 0, ev_order_irq = 0, ev_key_irq = 0;
   logic        ev_pen_detect = 0, ev_timer_start = 0, pen_switch = 0;
   logic [1:0]  ev_pen_disp = 0;
   logic        rsp_vld, irq_req, busy;
   logic [15:0] rsp_data;
   logic [9:0]  defl_x, defl_y;
   logic [31:0] ind;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk; // 50 MHz

   disp_status_unit u0 (.*);

   // ev: {regen, order, key, pen, timer, pensw}
   typedef struct packed {
      logic [1:0]  op;
      logic [4:0]  dev;
      logic [15:0] data;
      logic [5:0]  ev;
      logic [1:0]  disp;
      logic        cfg;
      logic [1:0]  mode;
      logic        pdet;
      logic        pirq;
      logic        lvl;
      logic        xv;
      logic [15:0] xd;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t TAB [0:NV-1] = '{
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 8'd5},  // R5 R2
      '{2'd3, 5'h1F, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 8'd11}, // R11
      '{2'd0, 5'h00, 16'h0000, 6'b000100, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd13},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 8'd2},  // R2 detect ignored
      '{2'd0, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd14},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4400, 8'd14}, // R14 point
      '{2'd0, 5'h00, 16'h0000, 6'b000100, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd6},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4410, 8'd6},  // R6 deferred
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4400, 8'd6},  // R6 read clears
      '{2'd0, 5'h00, 16'h0000, 6'b000011, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd14},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4480, 8'd14}, // R14 pen switch
      '{2'd0, 5'h00, 16'h0000, 6'b100000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd7},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100, 8'd4},  // R4
      '{2'd2, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'd9},  // R9 none pending
      '{2'd0, 5'h00, 16'h0000, 6'b001000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd7},
      '{2'd2, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd9},  // R9 level low
      '{2'd2, 5'h0A, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0010, 8'd8},  // R8
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4482, 8'd7},  // R7 busy dropped
      '{2'd0, 5'h00, 16'h0000, 6'b100000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd7},
      '{2'd3, 5'h00, 16'h0100, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4482, 8'd7},  // R7 start ignored
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4480, 8'd10}, // R10
      '{2'd0, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd14},
      '{2'd0, 5'h00, 16'h0000, 6'b000100, 2'b11, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd6},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hC284, 8'd6},  // R6 detect irq
      '{2'd0, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd14},
      '{2'd0, 5'h00, 16'h0000, 6'b000100, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd6},
      '{2'd0, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd14},
      '{2'd0, 5'h00, 16'h0000, 6'b000100, 2'b10, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd6},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8284, 8'd6},  // R6 status cleared
      '{2'd3, 5'h15, 16'h0100, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8284, 8'd10},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8280, 8'd10}, // R10
      '{2'd1, 5'h1F, 16'hA5C3, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'd1},  // R1
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 8'd2},  // R2
      '{2'd0, 5'h00, 16'h0000, 6'b010000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd13},
      '{2'd3, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4001, 8'd5},
      '{2'd2, 5'h00, 16'h0000, 6'b000000, 2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0010, 8'd8}   // R8
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      cmd_vld = 0; cmd_op = 0; cmd_dev = 0; cmd_data = 0; host_lvl_act = 0;
      cfg_we = 0; defl_we = 0;
      ev_regen_start = 0; ev_order_irq = 0; ev_key_irq = 0;
      ev_pen_detect = 0; ev_timer_start = 0; pen_switch = 0; ev_pen_disp = 0;
   endtask

   task automatic drive(input vec_t v);
      cmd_vld = (v.op != 2'd0); cmd_op = v.op; cmd_dev = v.dev; cmd_data = v.data;
      host_lvl_act = v.lvl;
      cfg_we = v.cfg; cfg_mode = v.mode; cfg_pen_det = v.pdet; cfg_pen_irq = v.pirq;
      {ev_regen_start, ev_order_irq, ev_key_irq, ev_pen_detect, ev_timer_start, pen_switch} = v.ev;
      ev_pen_disp = v.disp;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic cmd(input logic [1:0] op, input logic [15:0] data);
      cmd_vld = 1; cmd_op = op; cmd_data = data;
      tick();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state, R1 R3 R12 R13
      check("R1 defl_x after reset", 32'(defl_x), 32'd512);
      check("R1 defl_y after reset", 32'(defl_y), 32'd512);
      check("R3 indicators after reset", ind, 32'h0);
      check("R12 irq_req after reset", 32'(irq_req), 32'd0);
      check("R13 rsp_vld idle", 32'(rsp_vld), 32'd0);
      check("R1 busy after reset", 32'(busy), 32'd0);

      for (int i = 0; i < NV; i++) begin
         drive(TAB[i]);
         tick();
         check($sformatf("R%0d row %0d rsp_vld", TAB[i].rq, i), 32'(rsp_vld), 32'(TAB[i].xv));
         if (TAB[i].xv)
            check($sformatf("R%0d row %0d rsp_data", TAB[i].rq, i), 32'(rsp_data), 32'(TAB[i].xd));
      end

      // after table: order pending, indicators from reset data A5C3
      check("R3 mirrored indicators", ind, 32'hA5C3A5C3);
      check("R1 defl after reset cmd", {defl_x, defl_y}, {10'd512, 10'd512});
      check("R12 irq_req with order pending", 32'(irq_req), 32'd1);

      // deflection load, R14
      defl_we = 1; defl_x_in = 10'd100; defl_y_in = 10'd900;
      tick();
      check("R14 defl load", {defl_x, defl_y}, {10'd100, 10'd900});

      // reset wins over a same-cycle deflection load, R1 R3
      defl_we = 1; defl_x_in = 10'd7; defl_y_in = 10'd8;
      cmd_dev = 5'h1F;
      cmd(2'd1, 16'h0F0F);
      check("R13 reset rsp pulse", {31'd0, rsp_vld}, 32'd1);
      check("R1 reset over defl load", {defl_x, defl_y}, {10'd512, 10'd512});
      check("R3 second pattern", ind, 32'h0F0F0F0F);
      check("R1 irq cleared", 32'(irq_req), 32'd0);
      tick();
      check("R13 pulse is one cycle", 32'(rsp_vld), 32'd0);

      // busy interplay, R7 R12
      ev_regen_start = 1;
      tick();
      check("R7 busy set", 32'(busy), 32'd1);
      check("R12 irq_req low while busy", 32'(irq_req), 32'd0);
      ev_key_irq = 1;
      tick();
      check("R7 busy cleared by event", 32'(busy), 32'd0);
      check("R12 irq_req high", 32'(irq_req), 32'd1);
      cmd(2'd3, 16'h0100);
      check("R10 word before clear", 32'(rsp_data), 32'h4002);
      check("R12 irq_req after clear", 32'(irq_req), 32'd0);

      summary();
   end
endmodule